// File: doc/BRIEF.md
# Two-Port Memory Request Arbiter

This block sits between one SDRAM controller command port and two FIFO controllers. One of them drains captured video into memory with write bursts. The other refills a display buffer with read bursts. The controller accepts a single request at a time, so the arbiter chooses one requester, gives it the memory port for a whole burst, and hides the other until that burst is over.

The arbiter does nothing until the controller reports that its start-up sequence is complete. After that, it samples both request lines on the same edge. The read (display) side has fixed priority, because an empty display buffer is visible on screen. A grant captures the winner's burst address and direction in registers and drives them to the controller. Acknowledge, per-word strobes, read data and the end-of-burst indication are routed only to the requester that holds the grant. The arbiter returns to polling only after the controller signals that the burst is complete.

Top module: `sdram_arb2`

## Requirements
- R1: While `ctrl_init_done_i` is low, `mem_req_o` stays low whatever the request lines do.
- R2: When only one requester is active in the polling state, it is granted on the next edge. The write side drives `mem_we_o`=1 with `dec_addr_i`. The read side drives `mem_we_o`=0 with `enc_addr_i`.
- R3: When both requesters are active in the same polling cycle, the read side is granted. The write side keeps its request pending and is granted once polling resumes.
- R4: When neither requester is active, the arbiter keeps polling and `mem_req_o` stays low.
- R5: `mem_req_o` is high from the grant until the cycle in which `mem_ack_i` is seen, then drops. Only one request is ever outstanding.
- R6: `mem_ack_i` appears on `dec_ack_o` or `enc_ack_o` only for the grant holder, never on both.
- R7: During a burst, `mem_wtake_i` reaches only `dec_wtake_o` during a write grant, and `mem_rvalid_i` and `mem_rdata_i` reach only `enc_rvalid_o`/`enc_rdata_o` during a read grant. `mem_wdata_o` carries `dec_wdata_i` during a write grant and zero otherwise.
- R8: After the acknowledge, request lines are ignored (`mem_req_o` stays low) until `mem_done_i`. The done pulse is routed only to the holder, and polling resumes on the next edge.
- R9: `mem_addr_o` and `mem_we_o` are registered at grant and remain stable through the burst, even when the requester changes its address inputs.
- R10: After reset, `mem_req_o` and every requester-side strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_init_done_i | input | 1 | Controller start-up complete |
| dec_req_i | input | 1 | Write-side burst request |
| dec_addr_i | input | ADDR_W | Write-side burst address |
| dec_wdata_i | input | DATA_W | Write-side data word |
| dec_ack_o | output | 1 | Write-side request accepted |
| dec_wtake_o | output | 1 | Write word consumed by controller |
| dec_done_o | output | 1 | Write burst finished |
| enc_req_i | input | 1 | Read-side burst request |
| enc_addr_i | input | ADDR_W | Read-side burst address |
| enc_ack_o | output | 1 | Read-side request accepted |
| enc_rvalid_o | output | 1 | Read word valid |
| enc_rdata_o | output | DATA_W | Read word |
| enc_done_o | output | 1 | Read burst finished |
| mem_req_o | output | 1 | Request to controller |
| mem_we_o | output | 1 | Direction, 1 = write |
| mem_addr_o | output | ADDR_W | Burst address to controller |
| mem_wdata_o | output | DATA_W | Write data to controller |
| mem_ack_i | input | 1 | Controller accepted request |
| mem_wtake_i | input | 1 | Controller consumes a write word |
| mem_rvalid_i | input | 1 | Controller presents a read word |
| mem_rdata_i | input | DATA_W | Read data from controller |
| mem_done_i | input | 1 | Controller finished the burst |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=16. With these widths every address and data word is unique and can be derived from the loop indices. It covers all four combinations of the request pair, acknowledge latencies of 0 to 3 cycles and bursts of 1 to 3 words. This brings every state transition within reach, including a pending write behind a read and an acknowledge in the first grant cycle. The bench stub moves addresses while a grant is open and keeps the loser requesting through the completion wait, so the latching and ignore rules are observed at the ports.

// File: rtl/sdram_arb_pkg.sv
package sdram_arb_pkg;
  localparam int NPORT    = 2;
  localparam int PORT_DEC = 0;  // write side
  localparam int PORT_ENC = 1;  // read side, higher priority

  typedef enum logic [1:0] {
    ST_POLL = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_DONE = 2'd3
  } arb_state_e;
endpackage

// File: rtl/sdram_arb_fsm.sv
module sdram_arb_fsm
  import sdram_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic [NPORT-1:0] req_i,
  input  logic             ack_i,
  input  logic             done_i,
  output arb_state_e       state_o,
  output logic [NPORT-1:0] sel_o,
  output logic             cap_o,
  output logic             cap_rd_o
);
  arb_state_e       state_q, state_d;
  logic [NPORT-1:0] sel_q, sel_d;

  assign cap_o    = (state_q == ST_POLL) && init_done_i && (|req_i);
  assign cap_rd_o = req_i[PORT_ENC];

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      ST_POLL: if (cap_o) begin
        sel_d = '0;
        if (req_i[PORT_ENC]) begin
          state_d = ST_RD;
          sel_d[PORT_ENC] = 1'b1;
        end else begin
          state_d = ST_WR;
          sel_d[PORT_DEC] = 1'b1;
        end
      end
      ST_WR, ST_RD: if (ack_i) state_d = ST_DONE;
      ST_DONE: if (done_i) begin
        state_d = ST_POLL;
        sel_d   = '0;
      end
      default: begin
        state_d = ST_POLL;
        sel_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POLL;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/sdram_arb_latch.sv
module sdram_arb_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              cap_rd_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic [ADDR_W-1:0] enc_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      we_o   <= 1'b0;
    end else if (cap_i) begin
      addr_o <= cap_rd_i ? enc_addr_i : dec_addr_i;
      we_o   <= !cap_rd_i;
    end
  end
endmodule

// File: rtl/sdram_arb_route.sv
module sdram_arb_route
  import sdram_arb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  arb_state_e        state_i,
  input  logic [NPORT-1:0]  sel_i,
  input  logic              ack_i,
  input  logic              wtake_i,
  input  logic              rvalid_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] dec_wdata_i,
  output logic [NPORT-1:0]  ack_o,
  output logic [NPORT-1:0]  strb_o,
  output logic [NPORT-1:0]  done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic granting, busy, finishing;
  assign granting  = (state_i == ST_WR) || (state_i == ST_RD);
  assign finishing = (state_i == ST_DONE);
  assign busy      = granting || finishing;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic src_strb;
    assign src_strb  = (p == PORT_DEC) ? wtake_i : rvalid_i;
    assign ack_o[p]  = ack_i    & sel_i[p] & granting;
    assign strb_o[p] = src_strb & sel_i[p] & busy;
    assign done_o[p] = done_i   & sel_i[p] & finishing;
  end

  assign rdata_o = (sel_i[PORT_ENC] && busy) ? rdata_i     : '0;
  assign wdata_o = (sel_i[PORT_DEC] && busy) ? dec_wdata_i : '0;
endmodule

// File: rtl/sdram_arb2.sv
module sdram_arb2
  import sdram_arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_init_done_i,
  input  logic              dec_req_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic [DATA_W-1:0] dec_wdata_i,
  output logic              dec_ack_o,
  output logic              dec_wtake_o,
  output logic              dec_done_o,
  input  logic              enc_req_i,
  input  logic [ADDR_W-1:0] enc_addr_i,
  output logic              enc_ack_o,
  output logic              enc_rvalid_o,
  output logic [DATA_W-1:0] enc_rdata_o,
  output logic              enc_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_wtake_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_done_i
);
  arb_state_e       state;
  logic [NPORT-1:0] sel, req, ack, strb, done;
  logic             cap, cap_rd;

  assign req[PORT_DEC] = dec_req_i;
  assign req[PORT_ENC] = enc_req_i;

  sdram_arb_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (ctrl_init_done_i),
    .req_i       (req),
    .ack_i       (mem_ack_i),
    .done_i      (mem_done_i),
    .state_o     (state),
    .sel_o       (sel),
    .cap_o       (cap),
    .cap_rd_o    (cap_rd)
  );

  sdram_arb_latch #(.ADDR_W(ADDR_W)) i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .cap_rd_i   (cap_rd),
    .dec_addr_i (dec_addr_i),
    .enc_addr_i (enc_addr_i),
    .addr_o     (mem_addr_o),
    .we_o       (mem_we_o)
  );

  sdram_arb_route #(.DATA_W(DATA_W)) i_route (
    .state_i     (state),
    .sel_i       (sel),
    .ack_i       (mem_ack_i),
    .wtake_i     (mem_wtake_i),
    .rvalid_i    (mem_rvalid_i),
    .done_i      (mem_done_i),
    .rdata_i     (mem_rdata_i),
    .dec_wdata_i (dec_wdata_i),
    .ack_o       (ack),
    .strb_o      (strb),
    .done_o      (done),
    .rdata_o     (enc_rdata_o),
    .wdata_o     (mem_wdata_o)
  );

  assign mem_req_o    = (state == ST_WR) || (state == ST_RD);
  assign dec_ack_o    = ack[PORT_DEC];
  assign enc_ack_o    = ack[PORT_ENC];
  assign dec_wtake_o  = strb[PORT_DEC];
  assign enc_rvalid_o = strb[PORT_ENC];
  assign dec_done_o   = done[PORT_DEC];
  assign enc_done_o   = done[PORT_ENC];
endmodule

// File: rtl/sdram_arb2_chk.sv
module sdram_arb2_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_init_done_i,
  input logic              dec_req_i,
  input logic              enc_req_i,
  input logic              dec_ack_o,
  input logic              enc_ack_o,
  input logic              dec_wtake_o,
  input logic              enc_rvalid_o,
  input logic              dec_done_o,
  input logic              enc_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  a_r1_wait_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(ctrl_init_done_i));

  a_r3_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && $past(enc_req_i)) |-> !mem_we_o);

  a_r2_write_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !$past(enc_req_i)) |-> (mem_we_o && $past(dec_req_i)));

  a_r5_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !mem_req_o);

  a_r6_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_ack_o, enc_ack_o}));

  a_r6_ack_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_ack_o |-> mem_we_o) and (enc_ack_o |-> !mem_we_o));

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_wtake_o, enc_rvalid_o}));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_done_o, enc_done_o}));

  a_r9_hold_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> ($stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind sdram_arb2 sdram_arb2_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .ctrl_init_done_i (ctrl_init_done_i),
  .dec_req_i        (dec_req_i),
  .enc_req_i        (enc_req_i),
  .dec_ack_o        (dec_ack_o),
  .enc_ack_o        (enc_ack_o),
  .dec_wtake_o      (dec_wtake_o),
  .enc_rvalid_o     (enc_rvalid_o),
  .dec_done_o       (dec_done_o),
  .enc_done_o       (enc_done_o),
  .mem_req_o        (mem_req_o),
  .mem_we_o         (mem_we_o),
  .mem_addr_o       (mem_addr_o),
  .mem_ack_i        (mem_ack_i)
);

// File: tb/test_sdram_arb2.sv
module test_sdram_arb2;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WDOG   = 50000;

  logic clk = 1'b0, rst_n = 1'b0, init_done = 1'b0;
  logic dec_req = 1'b0, enc_req = 1'b0;
  logic [ADDR_W-1:0] dec_addr = '0, enc_addr = '0;
  logic [DATA_W-1:0] dec_wdata = '0, mem_rdata = '0;
  logic mem_ack = 1'b0, mem_wtake = 1'b0, mem_rvalid = 1'b0, mem_done = 1'b0;
  logic dec_ack, dec_wtake, dec_done, enc_ack, enc_rvalid, enc_done;
  logic mem_req, mem_we;
  logic [DATA_W-1:0] enc_rdata, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_arb2 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sdram_arb2 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_init_done_i(init_done),
    .dec_req_i(dec_req), .dec_addr_i(dec_addr), .dec_wdata_i(dec_wdata),
    .dec_ack_o(dec_ack), .dec_wtake_o(dec_wtake), .dec_done_o(dec_done),
    .enc_req_i(enc_req), .enc_addr_i(enc_addr), .enc_ack_o(enc_ack),
    .enc_rvalid_o(enc_rvalid), .enc_rdata_o(enc_rdata), .enc_done_o(enc_done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_wtake_i(mem_wtake),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_done_i(mem_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WDOG);
      summary();
    end
  end

  // Acts as controller: grant is already visible at the current negedge.
  task automatic serve(input bit rd, input int lat, input int burst, input logic [ADDR_W-1:0] a);
    chk(mem_req == 1'b1, "R2 grant", mem_req, 1);
    chk(mem_we == !rd, "R2 direction", mem_we, !rd);
    chk(mem_addr == a, "R2 address", mem_addr, a);
    for (int i = 0; i < lat; i++) begin
      if (rd) enc_addr = enc_addr + 8'h55; else dec_addr = dec_addr + 8'h33;
      @(negedge clk); #1;
      chk(mem_req == 1'b1, "R5 request held", mem_req, 1);
      chk(mem_addr == a && mem_we == !rd, "R9 command stable", mem_addr, a);
    end
    mem_ack = 1'b1; #1;
    chk(enc_ack == rd && dec_ack == !rd, "R6 ack steering", {enc_ack, dec_ack}, {rd, !rd});
    if (rd) enc_req = 1'b0; else dec_req = 1'b0;
    @(negedge clk); mem_ack = 1'b0; #1;
    chk(mem_req == 1'b0, "R5 request dropped", mem_req, 0);
    chk(dec_ack == 1'b0 && enc_ack == 1'b0, "R6 no ack after", {enc_ack, dec_ack}, 0);
    for (int k = 0; k < burst; k++) begin
      @(negedge clk);
      if (rd) begin
        mem_rvalid = 1'b1; mem_rdata = DATA_W'(16'hA000 + a * 4 + k);
      end else begin
        mem_wtake = 1'b1; dec_wdata = DATA_W'(16'h5000 + a * 4 + k);
      end
      #1;
      chk(enc_rvalid == rd && dec_wtake == !rd, "R7 strobe steering", {enc_rvalid, dec_wtake}, {rd, !rd});
      if (rd) begin
        chk(enc_rdata == mem_rdata, "R7 read data", enc_rdata, mem_rdata);
        chk(mem_wdata == '0, "R7 write data idle", mem_wdata, 0);
      end else begin
        chk(mem_wdata == dec_wdata, "R7 write data", mem_wdata, dec_wdata);
      end
      chk(mem_req == 1'b0, "R8 requests ignored", mem_req, 0);
      mem_rvalid = 1'b0; mem_wtake = 1'b0;
    end
    @(negedge clk); mem_done = 1'b1; #1;
    chk(enc_done == rd && dec_done == !rd, "R8 done steering", {enc_done, dec_done}, {rd, !rd});
    @(negedge clk); mem_done = 1'b0; #1;
    chk(dec_done == 1'b0 && enc_done == 1'b0, "R8 done cleared", {enc_done, dec_done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req == 1'b0, "R10 reset req", mem_req, 0);
    chk({dec_ack, enc_ack, dec_wtake, enc_rvalid, dec_done, enc_done} == '0, "R10 reset strobes", 0, 0);
    rst_n = 1'b1;
    dec_req = 1'b1; enc_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk(mem_req == 1'b0, "R1 held before init", mem_req, 0);
    end
    dec_req = 1'b0; enc_req = 1'b0;
    @(negedge clk); init_done = 1'b1;

    for (int c = 0; c < 4; c++)
      for (int lat = 0; lat < 4; lat++)
        for (int b = 1; b < 4; b++) begin
          logic [ADDR_W-1:0] da, ea;
          da = ADDR_W'(c * 48 + lat * 12 + b * 2);
          ea = ADDR_W'(da + 1);
          @(negedge clk);
          dec_addr = da; enc_addr = ea;
          dec_req = c[0]; enc_req = c[1];
          @(negedge clk); #1;
          if (c == 0) begin
            chk(mem_req == 1'b0, "R4 idle poll", mem_req, 0);
            @(negedge clk); #1;
            chk(mem_req == 1'b0, "R4 still idle", mem_req, 0);
          end else if (c == 3) begin
            chk(mem_we == 1'b0, "R3 read wins", mem_we, 0);
            serve(1'b1, lat, b, ea);
            dec_addr = da;
            @(negedge clk); #1;
            chk(mem_req == 1'b1, "R3 pending write granted", mem_req, 1);
            serve(1'b0, lat, b, da);
          end else begin
            serve(c[1], lat, b, c[1] ? ea : da);
          end
        end
    summary();
  end
endmodule